// File: doc/BRIEF.md
# Write-Update Snooping Line Controller

This block tracks the coherence of a single line held in one private cache of a snooping multiprocessor that keeps copies consistent by broadcasting writes rather than invalidating them. It owns the line's state register and its one data word. The processor side presents reads, writes, read misses, write misses and evictions. The bus side presents snooped reads and update broadcasts, a wired-OR shared line, and a request/grant pair through which this cache issues its own reads, updates and write-backs.

A write to a line that other caches also hold is published as an update carrying the new word. The local copy is left alone until the bus is granted, so two caches can never both change their copies before either broadcast has been ordered. When the shared line shows no other holder, the cache takes the line into its private modified state and the bus stays quiet. A snooped read of a dirty line is answered with a flush. A snooped update overwrites the local word and gives ownership to the writer.

The processor holds its request steady until `cpuDone` is high. Requests that need no bus complete in the cycle they are presented. Requests that need the bus complete in the cycle of the final grant.

Top module: `wupd_line_ctrl`

## Requirements
- R1: After reset `lineState` is 0 (not present), and `busReq`, `snpFlush` and `cpuDone` are low. State codes: 0 not present, 1 exclusive-clean, 2 shared-clean, 3 shared-modified, 4 modified. Processor op codes: 0 read hit, 1 write hit, 2 read miss, 3 write miss, 4 evict. Bus command codes on `busCmd`: 0 none, 1 read, 2 update, 3 flush.
- R2: A read hit completes in the cycle it is presented (`cpuDone` high), changes neither state nor data, and raises no bus request.
- R3: A write hit in modified stores `cpuWdata` and stays modified. A write hit in exclusive-clean stores the word and moves to modified. Both complete at once with no bus request.
- R4: A write hit in shared-clean or shared-modified with `sharedIn` high when the request is first presented requests the bus with `busCmd` 2 and `busData` equal to the write word. `lineData` does not change while the grant is awaited. In the grant cycle the word is stored, the state becomes shared-modified, and `cpuDone` is high.
- R5: A write hit in shared-clean or shared-modified with `sharedIn` low stores the word, moves to modified and completes at once with no bus request.
- R6: A read miss requests `busCmd` 1. In the grant cycle `busFill` is loaded, and the state becomes shared-clean if `sharedIn` is high and exclusive-clean if it is low.
- R7: A write miss requests `busCmd` 1. If `sharedIn` is low at that grant, the write word is stored and the state becomes modified. If it is high, the fill is loaded as shared-clean and a second request with `busCmd` 2 follows, carrying the write word. The line ends in shared-modified holding that word.
- R8: A snooped read (`snpValid` with `snpUpd` low) raises `snpFlush` in the same cycle when the line is modified or shared-modified, with the word on `lineData`. Modified then becomes shared-modified, and shared-modified stays. In exclusive-clean or shared-clean there is no flush and no change.
- R9: A snooped update (`snpUpd` high) loads `snpData` into a shared-clean or shared-modified line and leaves it shared-clean.
- R10: Evicting a modified or shared-modified line requests `busCmd` 3 with the line word on `busData`, and the line becomes not present in the grant cycle. Evicting an exclusive-clean or shared-clean line makes it not present at once, with no bus request.
- R11: A snoop takes precedence over a processor request in the same cycle. `cpuDone` stays low and the processor request has no effect in that cycle. The request completes afterwards.
- R12: Once raised, `busReq` and `busCmd` stay unchanged until `busGnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present, held until cpuDone |
| cpuOp | input | 3 | Processor operation code |
| cpuWdata | input | DW | Processor write word |
| cpuDone | output | 1 | Request completes at this clock edge |
| sharedIn | input | 1 | Wired-OR shared line sample |
| busReq | output | 1 | Bus request |
| busCmd | output | 2 | Command for the requested tenure |
| busData | output | DW | Word driven with update or flush |
| busGnt | input | 1 | Bus grant, one cycle per tenure |
| busFill | input | DW | Fill word returned in a read grant cycle |
| snpValid | input | 1 | Snooped transaction for this line |
| snpUpd | input | 1 | Snooped kind: 0 read, 1 update |
| snpData | input | DW | Word carried by a snooped update |
| snpFlush | output | 1 | Flush response to a snooped read |
| lineState | output | 3 | Current line state code |
| lineData | output | DW | Current line word |

## Verification
The assertions assume the rest of the system behaves correctly. A grant never coincides with a snoop. Snooped updates never hit an exclusive-clean or modified line, because another holder would have kept it out of those states. The processor presents misses only for absent lines and other operations only for present ones, and it holds its request steady until completion. The stimulus always reaches each starting state through legal processor sequences from reset. It applies snoops only where a real bus could produce them, keeps grants and snoops in separate cycles, and delays grants by one or two cycles so that the hold properties see real waiting cycles.

// File: rtl/wupd_pkg.sv
package wupd_pkg;

  typedef enum logic [2:0] {
    LN_NONE  = 3'd0,
    LN_EXCL  = 3'd1,
    LN_SHCLN = 3'd2,
    LN_SHMOD = 3'd3,
    LN_MOD   = 3'd4
  } lineSt_e;

  typedef enum logic [2:0] {
    OP_RD     = 3'd0,
    OP_WR     = 3'd1,
    OP_RDMISS = 3'd2,
    OP_WRMISS = 3'd3,
    OP_EVICT  = 3'd4
  } cpuOp_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_RD    = 2'd1,
    BC_UPD   = 2'd2,
    BC_FLUSH = 2'd3
  } busCmd_e;

  typedef enum logic [1:0] {
    DS_CPU   = 2'd0,
    DS_FILL  = 2'd1,
    DS_SNOOP = 2'd2
  } dataSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     stWe;
    lineSt_e  stNext;
    logic     dataWe;
    dataSel_e dataSel;
  } strobes_t;

endpackage

// File: rtl/wupd_dpath.sv
module wupd_dpath
  import wupd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  busCmd_e       busCmd,
  input  logic [DW-1:0] cpuWdata,
  input  logic [DW-1:0] busFill,
  input  logic [DW-1:0] snpData,
  output lineSt_e       lineSt,
  output logic [DW-1:0] lineData,
  output logic [DW-1:0] busData
);

  lineSt_e       stQ;
  logic [DW-1:0] dataQ;
  logic [DW-1:0] dataD;

  always_comb begin
    case (strb.dataSel)
      DS_FILL:  dataD = busFill;
      DS_SNOOP: dataD = snpData;
      default:  dataD = cpuWdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= LN_NONE;
      dataQ <= '0;
    end else begin
      if (strb.stWe)   stQ   <= strb.stNext;
      if (strb.dataWe) dataQ <= dataD;
    end
  end

  always_comb begin
    case (busCmd)
      BC_UPD:   busData = cpuWdata;
      BC_FLUSH: busData = dataQ;
      default:  busData = '0;
    endcase
  end

  assign lineSt   = stQ;
  assign lineData = dataQ;

  // R1: state register only ever holds one of the five legal codes
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    stQ inside {LN_NONE, LN_EXCL, LN_SHCLN, LN_SHMOD, LN_MOD});

endmodule

// File: rtl/wupd_ctrl.sv
module wupd_ctrl
  import wupd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuValid,
  input  logic [2:0]    cpuOp,
  input  logic          sharedIn,
  input  logic          busGnt,
  input  logic          snpValid,
  input  logic          snpUpd,
  input  lineSt_e       lineSt,
  input  logic [DW-1:0] lineData,
  output strobes_t      strb,
  output logic          busReq,
  output busCmd_e       busCmd,
  output logic          cpuDone,
  output logic          snpFlush
);

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_UPD, PH_FL} phase_e;

  phase_e phaseQ, phaseD;
  logic   isShared;
  logic   isDirty;

  assign isShared = (lineSt == LN_SHCLN) || (lineSt == LN_SHMOD);
  assign isDirty  = (lineSt == LN_MOD) || (lineSt == LN_SHMOD);

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  always_comb begin
    case (phaseQ)
      PH_RD:   busCmd = BC_RD;
      PH_UPD:  busCmd = BC_UPD;
      PH_FL:   busCmd = BC_FLUSH;
      default: busCmd = BC_NONE;
    endcase
    busReq = (phaseQ != PH_IDLE);
  end

  always_comb begin
    strb     = '0;
    phaseD   = phaseQ;
    cpuDone  = 1'b0;
    snpFlush = 1'b0;
    if (snpValid) begin
      // snooped traffic owns the state register this cycle
      if (!snpUpd) begin
        snpFlush = isDirty;
        if (lineSt == LN_MOD) begin
          strb.stWe   = 1'b1;
          strb.stNext = LN_SHMOD;
        end
      end else if (isShared) begin
        strb.stWe    = 1'b1;
        strb.stNext  = LN_SHCLN;
        strb.dataWe  = 1'b1;
        strb.dataSel = DS_SNOOP;
      end
    end else begin
      case (phaseQ)
        PH_IDLE: if (cpuValid) begin
          case (cpuOp)
            OP_WR: begin
              if (isShared && sharedIn) begin
                phaseD = PH_UPD;
              end else begin
                cpuDone = 1'b1;
                if (lineSt != LN_NONE) begin
                  strb.stWe    = 1'b1;
                  strb.stNext  = LN_MOD;
                  strb.dataWe  = 1'b1;
                  strb.dataSel = DS_CPU;
                end
              end
            end
            OP_RDMISS, OP_WRMISS: phaseD = PH_RD;
            OP_EVICT: begin
              if (isDirty) begin
                phaseD = PH_FL;
              end else begin
                strb.stWe   = 1'b1;
                strb.stNext = LN_NONE;
                cpuDone     = 1'b1;
              end
            end
            default: cpuDone = 1'b1;
          endcase
        end
        PH_RD: if (busGnt) begin
          strb.stWe   = 1'b1;
          strb.dataWe = 1'b1;
          if (cpuOp == OP_WRMISS && !sharedIn) begin
            strb.stNext  = LN_MOD;
            strb.dataSel = DS_CPU;
            cpuDone      = 1'b1;
            phaseD       = PH_IDLE;
          end else if (cpuOp == OP_WRMISS) begin
            strb.stNext  = LN_SHCLN;
            strb.dataSel = DS_FILL;
            phaseD       = PH_UPD;
          end else begin
            strb.stNext  = sharedIn ? LN_SHCLN : LN_EXCL;
            strb.dataSel = DS_FILL;
            cpuDone      = 1'b1;
            phaseD       = PH_IDLE;
          end
        end
        PH_UPD: if (busGnt) begin
          strb.stWe    = 1'b1;
          strb.stNext  = LN_SHMOD;
          strb.dataWe  = 1'b1;
          strb.dataSel = DS_CPU;
          cpuDone      = 1'b1;
          phaseD       = PH_IDLE;
        end
        default: if (busGnt) begin
          strb.stWe   = 1'b1;
          strb.stNext = LN_NONE;
          cpuDone     = 1'b1;
          phaseD      = PH_IDLE;
        end
      endcase
    end
  end

  // R2: a read hit leaves state and word untouched
  p_rdhit_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!snpValid && phaseQ == PH_IDLE && cpuValid && cpuOp == OP_RD)
      |=> ($stable(lineSt) && $stable(lineData) && !busReq));

  // R4: local word frozen while an update waits for its grant
  p_upd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_UPD && !busGnt && !snpValid) |=> (lineData == $past(lineData)));

  // R8: snooped read of a modified line leaves it shared-modified
  p_snprd_mod_r8: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && !snpUpd && lineSt == LN_MOD) |=> (lineSt == LN_SHMOD));

  // R9: snooped update of a shared-modified line hands ownership away
  p_snpupd_own_r9: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpUpd && lineSt == LN_SHMOD) |=> (lineSt == LN_SHCLN));

  // R10: clean eviction is immediate and silent
  p_evict_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!snpValid && phaseQ == PH_IDLE && cpuValid && cpuOp == OP_EVICT &&
     (lineSt == LN_EXCL || lineSt == LN_SHCLN))
      |=> (lineSt == LN_NONE && !busReq));

  // R12: request and command held until granted
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> (busReq && busCmd == $past(busCmd)));

endmodule

// File: rtl/wupd_line_ctrl.sv
module wupd_line_ctrl
  import wupd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuValid,
  input  logic [2:0]    cpuOp,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuDone,
  input  logic          sharedIn,
  output logic          busReq,
  output logic [1:0]    busCmd,
  output logic [DW-1:0] busData,
  input  logic          busGnt,
  input  logic [DW-1:0] busFill,
  input  logic          snpValid,
  input  logic          snpUpd,
  input  logic [DW-1:0] snpData,
  output logic          snpFlush,
  output logic [2:0]    lineState,
  output logic [DW-1:0] lineData
);

  strobes_t      strb;
  busCmd_e       cmdInt;
  lineSt_e       stInt;
  logic [DW-1:0] dataInt;

  wupd_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuValid (cpuValid),
    .cpuOp    (cpuOp),
    .sharedIn (sharedIn),
    .busGnt   (busGnt),
    .snpValid (snpValid),
    .snpUpd   (snpUpd),
    .lineSt   (stInt),
    .lineData (dataInt),
    .strb     (strb),
    .busReq   (busReq),
    .busCmd   (cmdInt),
    .cpuDone  (cpuDone),
    .snpFlush (snpFlush)
  );

  wupd_dpath #(.DW(DW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busCmd   (cmdInt),
    .cpuWdata (cpuWdata),
    .busFill  (busFill),
    .snpData  (snpData),
    .lineSt   (stInt),
    .lineData (dataInt),
    .busData  (busData)
  );

  assign busCmd    = cmdInt;
  assign lineState = stInt;
  assign lineData  = dataInt;

endmodule

// File: tb/test_wupd_line_ctrl.sv
module test_wupd_line_ctrl;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuValid = 1'b0;
  logic [2:0]    cpuOp = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuDone;
  logic          sharedIn = 1'b0;
  logic          busReq;
  logic [1:0]    busCmd;
  logic [DW-1:0] busData;
  logic          busGnt = 1'b0;
  logic [DW-1:0] busFill = '0;
  logic          snpValid = 1'b0;
  logic          snpUpd = 1'b0;
  logic [DW-1:0] snpData = '0;
  logic          snpFlush;
  logic [2:0]    lineState;
  logic [DW-1:0] lineData;

  int nChk = 0;
  int nBad = 0;

  // transaction observations
  int            nG;
  logic [1:0]    gCmd [2];
  logic [DW-1:0] gData [2];
  bit            holdBad;
  bit            updMoved;
  int            doneIter;

  always #10 clk = ~clk;

  wupd_line_ctrl #(.DW(DW)) i_wupd_line_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuOp(cpuOp),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .sharedIn(sharedIn),
    .busReq(busReq), .busCmd(busCmd), .busData(busData), .busGnt(busGnt),
    .busFill(busFill), .snpValid(snpValid), .snpUpd(snpUpd),
    .snpData(snpData), .snpFlush(snpFlush), .lineState(lineState),
    .lineData(lineData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cpuValid = 1'b0; busGnt = 1'b0; snpValid = 1'b0;
    sharedIn = 1'b0; snpUpd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic txn(input logic [2:0] op, input logic [DW-1:0] wd,
                     input logic sh, input logic [DW-1:0] fill, input int dly);
    int waitc = 0;
    bit fin = 1'b0;
    bit prevReq = 1'b0;
    bit prevUpd = 1'b0;
    logic [1:0] prevCmd = '0;
    logic [DW-1:0] prevD = '0;
    nG = 0; holdBad = 1'b0; updMoved = 1'b0; doneIter = -1;
    gCmd[0] = '0; gCmd[1] = '0; gData[0] = '0; gData[1] = '0;
    @(negedge clk);
    cpuValid = 1'b1; cpuOp = op; cpuWdata = wd; sharedIn = sh; busFill = fill;
    for (int c = 0; c < 40 && !fin; c++) begin
      #2;
      if (prevReq && (!busReq || busCmd !== prevCmd)) holdBad = 1'b1;
      if (prevUpd && lineData !== prevD) updMoved = 1'b1;
      prevReq = 1'b0; prevUpd = 1'b0;
      if (busReq) begin
        if (waitc == dly) begin
          busGnt = 1'b1;
          if (nG < 2) begin gCmd[nG] = busCmd; gData[nG] = busData; end
          nG++; waitc = 0;
        end else begin
          waitc++; prevReq = 1'b1; prevCmd = busCmd;
          if (busCmd == 2'd2) begin prevUpd = 1'b1; prevD = lineData; end
        end
      end
      #1;
      fin = cpuDone;
      if (fin) doneIter = c;
      @(negedge clk);
      busGnt = 1'b0;
    end
    cpuValid = 1'b0;
  endtask

  function automatic logic [DW-1:0] baseOf(input int st);
    case (st)
      1: return 16'h1E00;
      2: return 16'h5C00;
      3: return 16'h5D00;
      default: return 16'h4D00;
    endcase
  endfunction

  // build a starting state from reset through legal processor traffic
  task automatic reach(input int st);
    doReset();
    case (st)
      1: txn(3'd2, '0, 1'b0, baseOf(1), 1);
      2: txn(3'd2, '0, 1'b1, baseOf(2), 1);
      3: begin txn(3'd2, '0, 1'b1, 16'h0101, 0); txn(3'd1, baseOf(3), 1'b1, '0, 1); end
      default: begin txn(3'd2, '0, 1'b0, 16'h0202, 0); txn(3'd1, baseOf(4), 1'b0, '0, 0); end
    endcase
    #1;
    chk("setup", lineState, st);
  endtask

  initial begin
    #(200000 * 20);
    nBad++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    #1;
    chk("R1 state", lineState, 3'd0);
    chk("R1 busReq", busReq, 1'b0);
    chk("R1 snpFlush", snpFlush, 1'b0);
    chk("R1 cpuDone", cpuDone, 1'b0);

    // hit sweep: every present state x read/write/evict x shared line
    for (int st = 1; st <= 4; st++) begin
      for (int k = 0; k < 3; k++) begin
        for (int sh = 0; sh < 2; sh++) begin
          logic [2:0] op;
          logic [DW-1:0] wd, base, expD, expGD;
          logic [2:0] expSt;
          int expN;
          logic [1:0] expC;
          string tag;
          op = (k == 0) ? 3'd0 : (k == 1) ? 3'd1 : 3'd4;
          base = baseOf(st);
          wd = 16'h7000 | DW'(st << 8) | DW'(k << 4) | DW'(sh);
          reach(st);
          txn(op, wd, sh[0], 16'hFFFF, 2);
          #1;
          expC = 2'd0; expGD = '0;
          if (op == 3'd0) begin
            tag = "R2"; expSt = st[2:0]; expD = base; expN = 0;
          end else if (op == 3'd1) begin
            if ((st == 2 || st == 3) && sh == 1) begin
              tag = "R4"; expSt = 3'd3; expD = wd; expN = 1; expC = 2'd2; expGD = wd;
            end else if (st == 2 || st == 3) begin
              tag = "R5"; expSt = 3'd4; expD = wd; expN = 0;
            end else begin
              tag = "R3"; expSt = 3'd4; expD = wd; expN = 0;
            end
          end else begin
            tag = "R10"; expSt = 3'd0; expD = base;
            if (st == 3 || st == 4) begin expN = 1; expC = 2'd3; expGD = base; end
            else expN = 0;
          end
          chk({tag, " state"}, lineState, expSt);
          chk({tag, " data"}, lineData, expD);
          chk({tag, " grants"}, nG, expN);
          if (expN > 0) begin
            chk({tag, " cmd"}, gCmd[0], expC);
            chk({tag, " busData"}, gData[0], expGD);
          end else begin
            chk({tag, " immediate done"}, doneIter, 0);
          end
          chk("R12 hold", holdBad, 1'b0);
          chk("R4 word held before grant", updMoved, 1'b0);
        end
      end
    end

    // miss sweep
    for (int sh = 0; sh < 2; sh++) begin
      doReset();
      txn(3'd2, '0, sh[0], 16'hA5A0 | DW'(sh), 1);
      #1;
      chk("R6 state", lineState, sh ? 3'd2 : 3'd1);
      chk("R6 data", lineData, 16'hA5A0 | DW'(sh));
      chk("R6 grants", nG, 1);
      chk("R6 cmd", gCmd[0], 2'd1);
      chk("R12 hold", holdBad, 1'b0);

      doReset();
      txn(3'd3, 16'h3C30 | DW'(sh), sh[0], 16'hF0F0, 2);
      #1;
      chk("R7 state", lineState, sh ? 3'd3 : 3'd4);
      chk("R7 data", lineData, 16'h3C30 | DW'(sh));
      chk("R7 grants", nG, sh ? 2 : 1);
      chk("R7 first cmd", gCmd[0], 2'd1);
      if (sh) begin
        chk("R7 second cmd", gCmd[1], 2'd2);
        chk("R7 update word", gData[1], 16'h3C31);
      end
      chk("R12 hold", holdBad, 1'b0);
      chk("R4 word held before grant", updMoved, 1'b0);
    end

    // snoop sweep
    for (int st = 1; st <= 4; st++) begin
      for (int u = 0; u < 2; u++) begin
        if (!(u == 1 && (st == 1 || st == 4))) begin
          logic [DW-1:0] base, sd;
          base = baseOf(st);
          sd = 16'hC0D0 | DW'(st);
          reach(st);
          @(negedge clk);
          snpValid = 1'b1; snpUpd = u[0]; snpData = sd;
          #2;
          if (u == 0) begin
            chk("R8 flush", snpFlush, (st == 3 || st == 4));
            chk("R8 flush word", lineData, base);
          end else begin
            chk("R9 no flush", snpFlush, 1'b0);
          end
          @(negedge clk);
          snpValid = 1'b0;
          #1;
          if (u == 0) begin
            chk("R8 state", lineState, (st == 4) ? 3'd3 : st[2:0]);
            chk("R8 data", lineData, base);
          end else begin
            chk("R9 state", lineState, 3'd2);
            chk("R9 data", lineData, sd);
          end
        end
      end
    end

    // R11 snoop precedence over a processor write
    reach(1);
    @(negedge clk);
    snpValid = 1'b1; snpUpd = 1'b0;
    cpuValid = 1'b1; cpuOp = 3'd1; cpuWdata = 16'hBEEF; sharedIn = 1'b0;
    #2;
    chk("R11 done held low", cpuDone, 1'b0);
    @(negedge clk);
    snpValid = 1'b0;
    #1;
    chk("R11 state untouched", lineState, 3'd1);
    chk("R11 data untouched", lineData, baseOf(1));
    #1;
    chk("R11 done after snoop", cpuDone, 1'b1);
    @(negedge clk);
    cpuValid = 1'b0;
    #1;
    chk("R11 state", lineState, 3'd4);
    chk("R11 data", lineData, 16'hBEEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule